// File: doc/BRIEF.md
# Oscillator Drift Trim Unit

This block divides a low-frequency oscillator pulse stream into a one-second tick and corrects the crystal's frequency error while doing so. Seconds are grouped into correction windows of either a short or a long length, 20 s or 60 s by default. In the last second of every window the prescaler period is made shorter or longer by a programmed number of oscillator pulses. Shortening the period speeds the clock up by adding pulses. Lengthening it slows the clock down by removing pulses. All other seconds last exactly the nominal prescaler period.

Software programs the correction through one 8-bit write. A busy flag rises when a value is accepted. The value stays pending until the next window boundary. At that boundary it becomes the active setting and busy drops, so software must wait for busy low before writing again. The seconds counter that consumes the tick is outside this block.

Top module: `osc_trim`

## Requirements
- R1: With no correction active, every tick interval is exactly PRESCALE oscillator pulses. An interval is counted from the pulse after one tick up to and including the pulse that produces the next tick.
- R2: Written bit 7 selects the window length. 0 gives WIN_SHORT seconds and 1 gives WIN_LONG seconds. Only the last second of each window is corrected.
- R3: With bit 6 = 0 and code c = bits 5:0 nonzero, the last second of a window is shortened by 2*(c-1) pulses. Code 1 therefore gives no change, and code 63 gives 124 pulses.
- R4: With bit 6 = 1 and a nonzero code c, the last second is lengthened by 2*(63-c+1) pulses, that is, twice the 6-bit inverse of c plus one.
- R5: Code 0 gives no correction, whatever the value of bit 6.
- R6: An accepted write raises busy in the next cycle. The value is applied at the next window boundary, which is the tick that ends the last second. Busy falls at that same edge, and the new window length counts from the window that follows.
- R7: A write made while busy is high is ignored. Busy stays high and the earlier pending value is the one applied.
- R8: After reset, busy is low, the prescaler is cleared, the short window is selected and no correction is active.
- R9: A tick is produced only in a cycle that carries an oscillator pulse. Cycles without a pulse leave the prescaler unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | One-cycle strobe for each oscillator pulse |
| wrEn | input | 1 | Write strobe for the correction setting |
| wrData | input | 8 | Bit 7 window select, bit 6 direction, bits 5:0 code |
| secTick | output | 1 | Corrected one-second tick, asserted with an oscillator pulse |
| busy | output | 1 | High while a written setting waits for a window boundary |

## Verification
The bench builds the block with PRESCALE=300, WIN_SHORT=2 and WIN_LONG=3. Each window then lasts only a few thousand cycles, so dozens of window boundaries and setting transfers fit in one run. A prescaler of 300 still exceeds the largest correction of 126 pulses, so both code extremes can be tested: add code 63 and subtract codes 1 and 63. Writes made while busy is high are also exercised, along with writes that land right at a boundary under random oscillator pulse spacing.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  localparam int CODE_W  = 6;
  localparam int PULSE_W = CODE_W + 1;

  typedef struct packed {
    logic              longWin;
    logic              subtract;
    logic [CODE_W-1:0] code;
  } trimCfg_t;

  typedef struct packed {
    logic               lastSecond;
    logic               lengthen;
    logic [PULSE_W-1:0] pulses;
  } trimStrobe_t;

  function automatic logic [PULSE_W-1:0] pulsesOf(trimCfg_t cfg);
    logic [CODE_W-1:0] steps;
    if (cfg.code == '0)      steps = '0;
    else if (cfg.subtract)   steps = ~cfg.code + CODE_W'(1);
    else                     steps = cfg.code - CODE_W'(1);
    return {steps, 1'b0};
  endfunction
endpackage

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
  import osc_trim_pkg::*;
#(
  parameter int WIN_SHORT = 20,
  parameter int WIN_LONG  = 60
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  logic        secTick,
  output logic        busy,
  output trimStrobe_t strobe
);
  localparam int IW = $clog2(WIN_LONG + 1);

  trimCfg_t      pending;
  trimCfg_t      active;
  logic [IW-1:0] secIdx;
  logic [IW-1:0] lastIdx;
  logic          lastSecond;
  logic          boundary;

  assign lastIdx    = active.longWin ? IW'(WIN_LONG - 1) : IW'(WIN_SHORT - 1);
  assign lastSecond = (secIdx == lastIdx);
  assign boundary   = secTick && lastSecond;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secIdx  <= '0;
      pending <= '0;
      active  <= '0;
      busy    <= 1'b0;
    end else begin
      if (secTick) begin
        if (lastSecond) secIdx <= '0;
        else            secIdx <= secIdx + IW'(1);
      end
      if (boundary && busy) begin
        active <= pending;
        busy   <= 1'b0;
      end else if (wrEn && !busy) begin
        pending <= trimCfg_t'(wrData);
        busy    <= 1'b1;
      end
    end
  end

  assign strobe.lastSecond = lastSecond;
  assign strobe.lengthen   = active.subtract;
  assign strobe.pulses     = pulsesOf(active);

  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    secIdx <= lastIdx);
  assert_busy_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(boundary));
  assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> $stable(active));
  assert_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy) |=> (busy && pending == trimCfg_t'($past(wrData))));
  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy && !boundary) |=> (busy && $stable(pending)));
endmodule

// File: rtl/osc_trim_dp.sv
module osc_trim_dp
  import osc_trim_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        oscTick,
  input  trimStrobe_t strobe,
  output logic        secTick
);
  localparam int CW = $clog2(PRESCALE + (1 << PULSE_W));
  localparam logic [CW-1:0] TERM_NOM = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] term;

  always_comb begin
    term = TERM_NOM;
    if (strobe.lastSecond) begin
      if (strobe.lengthen) term = TERM_NOM + CW'(strobe.pulses);
      else                 term = TERM_NOM - CW'(strobe.pulses);
    end
  end

  assign secTick = oscTick && (cnt == term);

  always_ff @(posedge clk) begin
    if (!rstN)         cnt <= '0;
    else if (oscTick)  cnt <= secTick ? '0 : cnt + CW'(1);
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= term);
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (oscTick && !secTick) |=> cnt == $past(cnt) + CW'(1));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !oscTick |=> $stable(cnt));
endmodule

// File: rtl/osc_trim.sv
module osc_trim
  import osc_trim_pkg::*;
#(
  parameter int PRESCALE  = 32768,
  parameter int WIN_SHORT = 20,
  parameter int WIN_LONG  = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscTick,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic       secTick,
  output logic       busy
);
  trimStrobe_t strobe;

  osc_trim_ctrl #(.WIN_SHORT(WIN_SHORT), .WIN_LONG(WIN_LONG)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .secTick(secTick), .busy(busy), .strobe(strobe)
  );

  osc_trim_dp #(.PRESCALE(PRESCALE)) uDp (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .strobe(strobe),
    .secTick(secTick)
  );
endmodule

// File: tb/sim_osc_trim.sv
module sim_osc_trim;
  localparam int P  = 300;
  localparam int WS = 2;
  localparam int WL = 3;

  logic clk = 1'b0, rstN = 1'b0, oscTick = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  wire secTick, busy;

  always #2 clk = ~clk;

  osc_trim #(.PRESCALE(P), .WIN_SHORT(WS), .WIN_LONG(WL)) u0 (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .wrEn(wrEn),
    .wrData(wrData), .secTick(secTick), .busy(busy)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0, modelOn = 1'b0, ignoredPrev = 1'b0;
  int mCnt = 0, mIdx = 0;
  logic [7:0] act = 8'h00, pend = 8'h00;
  bit mBusy = 1'b0;

  function automatic int stepsOf(logic [7:0] v);
    int c = int'(v[5:0]);
    if (c == 0) return 0;
    if (v[6]) return 64 - c;
    return c - 1;
  endfunction

  function automatic bit isLast();
    return mIdx == ((act[7] ? WL : WS) - 1);
  endfunction

  function automatic int periodNow();
    if (!isLast()) return P;
    return act[6] ? P + 2 * stepsOf(act) : P - 2 * stepsOf(act);
  endfunction

  task automatic check(bit ok, string req, int actual, int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // reference model, sampled away from the active edge
  always @(negedge clk) begin
    if (modelOn) begin
      int per;
      bit expTick, last, wasBusy;
      string tag;
      per = periodNow();
      last = isLast();
      expTick = oscTick && (mCnt == per - 1);
      check(busy == mBusy, ignoredPrev ? "R7 busy" : "R6 busy", int'(busy), int'(mBusy));
      if (secTick || expTick) begin
        if (secTick && !oscTick) tag = "R9 tick without pulse";
        else if (!last) tag = "R2 plain second";
        else if (act[5:0] == 6'd0) tag = "R5 code zero";
        else if (act[6]) tag = "R4 lengthened second";
        else tag = "R3 shortened second";
        check(secTick == expTick, tag, int'(secTick), int'(expTick));
      end
      wasBusy = mBusy;
      if (oscTick) begin
        if (expTick) begin
          mCnt = 0;
          if (last) begin
            mIdx = 0;
            if (mBusy) begin act = pend; mBusy = 1'b0; end
          end else mIdx++;
        end else mCnt++;
      end
      if (wrEn && !wasBusy) begin pend = wrData; mBusy = 1'b1; end
      ignoredPrev = wrEn && wasBusy;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      oscTick = rstN && (($urandom % 10) < 7);
    end
  end

  task automatic doWrite(logic [7:0] v);
    @(posedge clk); #1;
    wrEn = 1'b1; wrData = v;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    logic [7:0] directed [6];
    void'($urandom(32'd4711));
    directed[0] = 8'h40; // subtract, code 0: R5
    directed[1] = 8'h01; // add, code 1: zero steps, R3
    directed[2] = 8'h3F; // add 62 steps = 124 pulses, R3
    directed[3] = 8'hC1; // long window, subtract 63 steps, R4 R2
    directed[4] = 8'h7F; // subtract code 63 -> 1 step, R4
    directed[5] = 8'h85; // long window add 4 steps, R2 R3
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    check(busy == 1'b0, "R8 busy after reset", int'(busy), 0);
    check(secTick == 1'b0, "R8 tick after reset", int'(secTick), 0);
    modelOn = 1'b1;
    // first window runs uncorrected: R1 via the model
    repeat (1500) @(posedge clk);
    for (int i = 0; i < 30; i++) begin
      logic [7:0] v;
      v = (i < 6) ? directed[i] : 8'($urandom);
      waitIdle();
      repeat ($urandom % 300) @(negedge clk);
      doWrite(v);
      if (($urandom % 3) == 0) doWrite(8'($urandom)); // R7: ignored
    end
    waitIdle();
    repeat (2500) @(posedge clk);
    finishRun();
  end
endmodule